// File: doc/BRIEF.md
# AIS-CI Signature Detector

This block watches an unframed received bit stream, one bit per clock, for the customer-installation variant of the alarm indication signal. That alarm is long stretches of all ones. At intervals the ones are overlaid with a repeating 6176-bit signature that has exactly three zeros at fixed offsets. The detector does not depend on any framing format. It treats any zero it sees while searching as the first signature zero, then follows the signature phase with a modulo counter. When one full signature period has matched exactly, it raises a single detection event.

A detection sets the latched output flag only if the separate AIS-present level is high in that same cycle. The flag then stays high until the host pulses the clear strobe. Each lock gives at most one detection. The flag therefore comes back once per signature burst (about every 1.2 s in service) while the alarm continues, and not on every signature period inside a burst.

Top module: `aisci_sig_detect`

## Requirements
- R1: While reset is held, and after it is released, `ci_flag` is 0.
- R2: The signature is 6176 bits long. Counting from 0, the bits at positions 3088, 3474 and 5790 are 0 and all other bits are 1. When the stream carries the signature starting at position 0, after any run of ones, the flag is still 0 after the bit at position 9262 is clocked in. It is 1 after the bit at position 9263 is clocked in, which is the 6176th bit counted from the zero at 3088.
- R3: Detection does not depend on where in the signature the stream starts. If the stream starts at position 4000, the flag is 0 after the bit at position 15438 and 1 after the bit at position 15439.
- R4: A zero where a one is expected breaks the match and is taken as a new first-zero candidate. An extra zero at position 4000 of the first period delays detection to the bit at position 15439; the flag is still 0 after the bit at position 9263.
- R5: A one where a zero is expected sends the detector back to search. If the zero at position 3474 of the first period is missing, the flag is 0 after the bit at position 9263 and 1 after the bit at position 15439.
- R6: A detection sets the flag only if `ais_present` is 1 in the detection cycle. With `ais_present` at 0 during detection, the flag stays 0 even if `ais_present` rises later in the same lock.
- R7: Once set, the flag holds until `rd_clr` is high at a clock edge. After that edge the flag reads 0.
- R8: Each lock gives one detection. After a clear, the flag stays 0 while the signature keeps matching. After the stream loses the signature and a new burst matches, the flag sets again.
- R9: If `rd_clr` and a qualified detection happen in the same cycle, the flag is 1 after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock; one received bit per rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_bit | input | 1 | Received data bit |
| ais_present | input | 1 | Level from the general AIS detector |
| rd_clr | input | 1 | Host clear-on-read strobe |
| ci_flag | output | 1 | Latched AIS-CI indication |

## Verification
The main test sends a clean signature after a run of ones and pins down the exact bit at which the flag rises. It is repeated with the stream starting mid-signature, which shows whether alignment follows the data or a fixed phase. Two corrupted streams follow: one with an extra zero and one with a missing zero. Each has a different recovery path, and the delayed detection bit shows that a mismatch really restarts the search and does not simply skip over the error. Further tests hold the AIS-present level low during detection, clear the flag while the lock continues, and clear in the detection cycle itself. These separate the qualification rule, the one-event-per-lock rule and the set-over-clear priority.

// File: rtl/aisci_sig_detect.sv
module aisci_sig_detect #(
  parameter int SIG_LEN = 6176,
  parameter int POS_A   = 3088,
  parameter int POS_B   = 3474,
  parameter int POS_C   = 5790
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_bit,
  input  logic ais_present,
  input  logic rd_clr,
  output logic ci_flag
);
  localparam int PW = $clog2(SIG_LEN);
  localparam logic [PW-1:0] LAST = PW'(SIG_LEN - 1);
  localparam logic [PW-1:0] ZA   = PW'(POS_A);
  localparam logic [PW-1:0] ZB   = PW'(POS_B);
  localparam logic [PW-1:0] ZC   = PW'(POS_C);

  logic          trk, locked;
  logic [PW-1:0] phase, cnt;
  logic [PW-1:0] nphase;
  logic          exp_zero, match, hit;

  assign nphase   = (phase == LAST) ? '0 : phase + 1'b1;
  assign exp_zero = (nphase == ZA) || (nphase == ZB) || (nphase == ZC);
  assign match    = trk && (rx_bit != exp_zero);
  assign hit      = match && !locked && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trk    <= 1'b0;
      locked <= 1'b0;
      phase  <= '0;
      cnt    <= '0;
    end else if (match) begin
      phase <= nphase;
      if (cnt != LAST) cnt <= cnt + 1'b1;
      if (hit) locked <= 1'b1;
    end else if (!rx_bit) begin
      trk    <= 1'b1;
      locked <= 1'b0;
      phase  <= ZA;
      cnt    <= PW'(1);
    end else if (trk) begin
      trk    <= 1'b0;
      locked <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                  ci_flag <= 1'b0;
    else if (hit && ais_present) ci_flag <= 1'b1;
    else if (rd_clr)             ci_flag <= 1'b0;
  end
endmodule

module aisci_sig_detect_chk (
  input logic clk,
  input logic rst_n,
  input logic rx_bit,
  input logic ais_present,
  input logic rd_clr,
  input logic ci_flag,
  input logic hit,
  input logic trk
);
  a_r6_set_needs_ais: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ci_flag) |-> $past(ais_present));

  a_r8_set_from_event: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ci_flag) |-> $past(hit));

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ci_flag && !rd_clr) |=> ci_flag);

  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && !hit) |=> !ci_flag);

  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && ais_present) |=> ci_flag);

  a_r4_zero_starts_track: assert property (@(posedge clk) disable iff (!rst_n)
    (!trk && !rx_bit) |=> trk);
endmodule

bind aisci_sig_detect aisci_sig_detect_chk chk_i (
  .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit), .ais_present(ais_present),
  .rd_clr(rd_clr), .ci_flag(ci_flag), .hit(hit), .trk(trk)
);

// File: tb/aisci_sig_detect_tb.sv
module aisci_sig_detect_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, rx_bit = 1'b1, ais_present = 1'b0, rd_clr = 1'b0;
  logic ci_flag;
  int vectors = 0, miscmp = 0;
  int bad_pos = -1;
  logic bad_val = 1'b1;

  always #4 clk = ~clk;

  aisci_sig_detect dut_i (.clk(clk), .rst_n(rst_n), .rx_bit(rx_bit),
    .ais_present(ais_present), .rd_clr(rd_clr), .ci_flag(ci_flag));

  function automatic logic sig_bit(int i);
    int m = i % 6176;
    return !(m == 3088 || m == 3474 || m == 5790);
  endfunction

  task automatic chk(string req, logic exp);
    vectors++;
    if (ci_flag !== exp) begin
      miscmp++;
      $display("FAIL %s: ci_flag=%b expected %b", req, ci_flag, exp);
    end
  endtask

  task automatic send_range(int from, int to);
    for (int i = from; i <= to; i++) begin
      rx_bit = (i == bad_pos) ? bad_val : sig_bit(i);
      @(negedge clk);
    end
  endtask

  task automatic flush();
    bad_pos = -1;
    rx_bit = 1'b1;
    rd_clr = 1'b1;
    @(negedge clk);
    rd_clr = 1'b0;
    for (int i = 0; i < 7000; i++) @(negedge clk);
  endtask

  task automatic t_basic_and_clear();
    flush();
    ais_present = 1'b1;
    send_range(0, 9262);
    chk("R2 before full period", 1'b0);
    send_range(9263, 9263);
    chk("R2 detect at 6176th bit", 1'b1);
    send_range(9264, 9264 + 3000);
    chk("R7 flag holds", 1'b1);
    rd_clr = 1'b1;
    send_range(12265, 12265);
    rd_clr = 1'b0;
    chk("R7 clear", 1'b0);
    send_range(12266, 12266 + 2 * 6176);
    chk("R8 no re-set within lock", 1'b0);
    flush();
    send_range(0, 9263);
    chk("R8 re-set on new burst", 1'b1);
  endtask

  task automatic t_ais_off();
    flush();
    chk("R7 flush cleared", 1'b0);
    ais_present = 1'b0;
    send_range(0, 9263 + 6176);
    chk("R6 no set without ais", 1'b0);
    ais_present = 1'b1;
    send_range(9264 + 6176, 9263 + 2 * 6176);
    chk("R6 late ais no set", 1'b0);
  endtask

  task automatic t_extra_zero();
    flush();
    bad_pos = 4000; bad_val = 1'b0;
    send_range(0, 9263);
    chk("R4 extra zero blocks", 1'b0);
    send_range(9264, 15438);
    chk("R4 before realigned detect", 1'b0);
    send_range(15439, 15439);
    chk("R4 realigned detect", 1'b1);
  endtask

  task automatic t_missing_zero();
    flush();
    bad_pos = 3474; bad_val = 1'b1;
    send_range(0, 9263);
    chk("R5 missing zero blocks", 1'b0);
    send_range(9264, 15439);
    chk("R5 realigned detect", 1'b1);
  endtask

  task automatic t_offset();
    flush();
    send_range(4000, 15438);
    chk("R3 offset before", 1'b0);
    send_range(15439, 15439);
    chk("R3 offset detect", 1'b1);
  endtask

  task automatic t_set_wins();
    flush();
    send_range(0, 9262);
    chk("R9 before", 1'b0);
    rd_clr = 1'b1;
    send_range(9263, 9263);
    rd_clr = 1'b0;
    chk("R9 set wins over clear", 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 in reset", 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset", 1'b0);
    t_basic_and_clear();
    t_ais_off();
    t_extra_zero();
    t_missing_zero();
    t_offset();
    t_set_wins();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    vectors++;
    miscmp++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
    $finish;
  end
endmodule